// File: doc/BRIEF.md
# Rotating-start single-slot request merger

This block collects requests from several peers and moves them, one at a time, into a single output register that a downstream consumer drains. Each peer presents a valid flag and a payload. When the output register is empty, the block looks through the peers in a circular order beginning at a start index, picks the first peer that has data, pulses that peer's pop line and captures its payload. Only one peer can be served per cycle, because the slot holds a single entry.

The start index moves on by exactly one position, wrapping after the highest peer, on every cycle in which the slot began empty and ended full. It does not jump to the peer just after the winner. A build parameter switches the block into fixed-priority mode, in which the search always begins at peer 0. The consumer empties the slot by raising ready while the slot is valid. The slot is then empty, and open to a new grant, in the following cycle.

Top module: `rr_multigrant_arb`

## Requirements
- R1: After reset the output slot is empty (out_valid low), no pop is asserted, and the start index is 0, so with every peer requesting the first grant goes to peer 0.
- R2: In any cycle at most one bit of req_pop is high. It is high only for a peer whose req_valid is high, and only while out_valid is low.
- R3: While out_valid is low and any req_valid is high, exactly one peer is popped in that cycle. The popped payload appears on out_data with out_valid high on the next cycle.
- R4: The popped peer is the first requesting peer found when scanning upward from the start index to peer N-1 and then wrapping from peer 0 up to just below the start index.
- R5: In rotating mode the start index increases by one, wrapping from N-1 to 0, after each cycle in which a peer was popped. It is unchanged on every other cycle, whichever peer won.
- R6: A full slot keeps out_valid high and out_data stable until out_ready is seen high. In that cycle no peer is popped, and the slot is empty on the next cycle.
- R7: With FIXED_PRIO set, a pop always goes to the lowest-numbered requesting peer.
- R8: Every payload offered by a peer is delivered exactly once and in per-peer order. With all peers requesting continuously in rotating mode, no peer waits more than N grants between services.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PEERS | Per-peer flag: payload available |
| req_data | input | NUM_PEERS*DATA_W | Per-peer payloads, peer i at bits [i*DATA_W +: DATA_W] |
| req_pop | output | NUM_PEERS | Per-peer dequeue strobe, taken by the peer at the next rising edge |
| out_valid | output | 1 | Output slot holds an entry |
| out_data | output | DATA_W | Entry held in the output slot |
| out_ready | input | 1 | Consumer takes the entry this cycle |

## Verification
The bench targets the start index after a grant to a peer far from the start. A design that jumped to winner-plus-one would serve the wrong peer in the next full-contention round. It also runs idle stretches and stretches where the slot is full. A pointer that moved on those cycles would break the round-robin order that the reference model predicts. Random back-pressure checks that a full slot holds its payload and refuses pops, because a design that refilled during a drain would overwrite or duplicate entries. A second instance in fixed-priority mode is checked against lowest-index selection under random request patterns.

// File: rtl/rr_multigrant_arb.sv
module rr_multigrant_arb #(
  parameter int NUM_PEERS  = 4,
  parameter int DATA_W     = 8,
  parameter bit FIXED_PRIO = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PEERS-1:0]        req_valid,
  input  logic [NUM_PEERS*DATA_W-1:0] req_data,
  output logic [NUM_PEERS-1:0]        req_pop,
  output logic                        out_valid,
  output logic [DATA_W-1:0]           out_data,
  input  logic                        out_ready
);
  localparam int PTR_W = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_PEERS - 1);

  logic [PTR_W-1:0] start_q;
  logic [PTR_W-1:0] win_idx;
  logic             win_hit;
  logic             grant;

  // circular scan from start_q
  always_comb begin
    int idx;
    win_hit = 1'b0;
    win_idx = '0;
    for (int k = 0; k < NUM_PEERS; k++) begin
      idx = int'(start_q) + k;
      if (idx >= NUM_PEERS) idx = idx - NUM_PEERS;
      if (!win_hit && req_valid[idx]) begin
        win_hit = 1'b1;
        win_idx = PTR_W'(idx);
      end
    end
  end

  assign grant   = !out_valid && win_hit;
  assign req_pop = grant ? (NUM_PEERS'(1) << win_idx) : '0;

  generate
    if (FIXED_PRIO) begin : g_fixed
      assign start_q = '0;

      p_fixed_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_pop) |-> (((req_pop - NUM_PEERS'(1)) & req_valid) == '0));
    end else begin : g_rot
      always_ff @(posedge clk) begin
        if (!rst_n)     start_q <= '0;
        else if (grant) start_q <= (start_q == LAST) ? '0 : start_q + 1'b1;
      end

      p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_pop) |=> (start_q == (($past(start_q) == LAST) ? '0 : $past(start_q) + 1'b1)));
      p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_pop) |=> $stable(start_q));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (grant) begin
      out_valid <= 1'b1;
      out_data  <= req_data[int'(win_idx)*DATA_W +: DATA_W];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_single_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_pop));
  p_pop_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pop & ~req_valid) == '0);
  p_pop_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_pop) |-> !out_valid);
  p_work_conserve_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && |req_valid) |-> (|req_pop));
  p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_pop) |=> out_valid);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
endmodule

// File: tb/tb_rr_multigrant_arb.sv
module tb_rr_multigrant_arb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NP-1:0]    vld = '0;
  logic [NP*DW-1:0] dat = '0;
  logic             rdy = 1'b0;
  logic [NP-1:0]    pop;
  logic             ov;
  logic [DW-1:0]    od;

  logic [NP-1:0]    fx_vld = '0;
  logic [NP*DW-1:0] fx_dat = '0;
  logic [NP-1:0]    fx_pop;
  logic             fx_ov;
  logic [DW-1:0]    fx_od;

  rr_multigrant_arb #(.NUM_PEERS(NP), .DATA_W(DW), .FIXED_PRIO(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(vld), .req_data(dat), .req_pop(pop),
    .out_valid(ov), .out_data(od), .out_ready(rdy));

  rr_multigrant_arb #(.NUM_PEERS(NP), .DATA_W(DW), .FIXED_PRIO(1'b1)) dut_fx (
    .clk(clk), .rst_n(rst_n), .req_valid(fx_vld), .req_data(fx_dat), .req_pop(fx_pop),
    .out_valid(fx_ov), .out_data(fx_od), .out_ready(1'b1));

  logic [DW-1:0] fifo [NP][64];
  int head [NP];
  int tail [NP];
  int seq  [NP];
  int last_g [NP];
  bit m_full = 0;
  logic [DW-1:0] m_data = '0;
  int m_start = 0;
  int gcount = 0, pushed = 0, delivered = 0;
  bit sat_chk = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int winner();
    for (int k = 0; k < NP; k++) begin
      int idx;
      idx = (m_start + k) % NP;
      if (vld[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic push(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      fifo[p][tail[p] % 64] = DW'((p << 6) | (seq[p] % 64));
      seq[p]++;
      tail[p]++;
      pushed++;
    end
  endtask

  function automatic int pending();
    int s;
    s = 0;
    for (int p = 0; p < NP; p++) s += tail[p] - head[p];
    return s;
  endfunction

  task automatic step();
    int w;
    logic [NP-1:0] exp_pop, fx_exp;
    @(posedge clk);
    w = winner();
    if (!m_full && w >= 0) begin
      m_data = fifo[w][head[w] % 64];
      head[w]++;
      m_full = 1;
      if (sat_chk && last_g[w] >= 0)
        check(gcount - last_g[w] <= NP, "R8", "grant gap", gcount - last_g[w], NP);
      last_g[w] = gcount;
      gcount++;
      m_start = (m_start + 1) % NP;
    end else if (m_full && rdy) begin
      m_full = 0;
      delivered++;
    end
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    for (int p = 0; p < NP; p++) begin
      vld[p] = (head[p] != tail[p]);
      dat[p*DW +: DW] = fifo[p][head[p] % 64];
      fx_dat[p*DW +: DW] = DW'(p);
    end
    rdy = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[0] : 1'b0;
    fx_vld = lfsr[4:1];
    @(negedge clk);
    w = winner();
    exp_pop = (!m_full && w >= 0) ? (NP'(1) << w) : '0;
    check(pop == exp_pop, "R4", "pop (scan order)", int'(pop), int'(exp_pop));
    check($onehot0(pop) && !((|pop) && ov) && ((pop & ~vld) == '0), "R2", "pop legality",
          int'(pop), int'(exp_pop));
    if (!ov && (|vld)) check(|pop, "R3", "work conserving", int'(pop), int'(exp_pop));
    check(ov == m_full, "R6", "out_valid", int'(ov), int'(m_full));
    if (m_full) check(od == m_data, "R6", "out_data", int'(od), int'(m_data));
    fx_exp = (!fx_ov && (|fx_vld)) ? (fx_vld & (~fx_vld + 1'b1)) : '0;
    check(fx_pop == fx_exp, "R7", "fixed pop", int'(fx_pop), int'(fx_exp));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int s;
    for (int p = 0; p < NP; p++) begin
      head[p] = 0; tail[p] = 0; seq[p] = 0; last_g[p] = -1;
    end
    repeat (3) @(negedge clk);
    check(ov == 1'b0, "R1", "out_valid in reset", int'(ov), 0);
    check(pop == '0, "R1", "pop in reset", int'(pop), 0);
    rst_n = 1'b1;
    step();
    check(ov == 1'b0 && pop == '0, "R1", "idle after reset", int'(ov), 0);

    // saturated, consumer always ready
    for (int p = 0; p < NP; p++) push(p, 15);
    ready_mode = 0;
    sat_chk = 1;
    step();
    check(pop == NP'(1), "R1", "first grant peer 0", int'(pop), 1);
    while (pending() > 0 || m_full) step();
    sat_chk = 0;

    // single far peer then idle cycles, then full contention
    s = m_start;
    push((s + 2) % NP, 1);
    while (pending() > 0 || m_full) step();
    check(m_start == (s + 1) % NP, "R5", "model start", m_start, (s + 1) % NP);
    repeat (5) step();
    for (int p = 0; p < NP; p++) push(p, 2);
    step();
    check(pop == (NP'(1) << ((s + 1) % NP)), "R5", "advance by one",
          int'(pop), int'(NP'(1) << ((s + 1) % NP)));
    while (pending() > 0 || m_full) step();

    // consumer stalls: slot must hold
    push(1, 3);
    ready_mode = 2;
    repeat (6) step();
    check(ov == 1'b1 && pop == '0, "R6", "stalled slot", int'(pop), 0);
    ready_mode = 0;
    while (pending() > 0 || m_full) step();

    // random traffic and back-pressure
    ready_mode = 1;
    for (int c = 0; c < 600; c++) begin
      if (lfsr[5] && pending() < 40) push(int'(lfsr[7:6]), 1 + int'(lfsr[8]));
      step();
    end
    ready_mode = 0;
    for (int c = 0; c < 1000 && (pending() > 0 || m_full); c++) step();
    check(delivered == pushed && pending() == 0, "R8", "lossless delivery",
          delivered, pushed);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule